// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address sequence for one read or write burst inside an already open row. A controller loads a start column together with a burst-length code and a wrap-order bit taken from its copy of the mode register. The generator then presents one column address per clock for as long as its advance input is high. It flags the final beat of a fixed-length burst. A burst ends when that final beat is consumed or when an early stop arrives from a burst-stop or precharge command.

A new load is accepted on any cycle, including in the middle of a burst, because a fresh random column access may be issued every clock. Full-page bursts walk the whole 256-column row and keep circling until they are stopped.

Top module: `sdram_burst_colgen`

## Requirements
- R1: After reset `col_valid` and `last_beat` are low.
- R2: A cycle with `load` high makes `col_valid` high in the next cycle with `col` equal to the loaded `start_col`, whatever burst was in progress; `load` wins over `stop` and `advance`.
- R3: `burst_code` selects the length: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8, 7 gives full page.
- R4: With `interleave` low, a fixed burst of length L counts upward from the start column and wraps inside the aligned block of L columns that holds the start column.
- R5: With `interleave` high, beat n of a fixed burst of length L addresses the start column with its low log2(L) bits XORed with n.
- R6: `last_beat` is high exactly while the final beat of a fixed burst is presented; advancing on it drops `col_valid` in the next cycle.
- R7: In full-page mode the column increments by one modulo 256 on each advance, ignores `interleave`, continues past the wrap, and never raises `last_beat`.
- R8: `stop` high without `load` drops `col_valid` in the next cycle.
- R9: With `advance` low and no load or stop, `col` and `col_valid` hold; `advance` while idle has no effect.
- R10: The reserved codes 4, 5 and 6 behave as a 1-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | 1 | Start a new burst at `start_col` |
| start_col | input | 8 | First column of the burst |
| burst_code | input | 3 | Burst length code |
| interleave | input | 1 | 1 selects interleaved order, 0 sequential |
| advance | input | 1 | Step to the next beat |
| stop | input | 1 | Terminate the burst early |
| col | output | 8 | Current column address |
| col_valid | output | 1 | A burst beat is being presented |
| last_beat | output | 1 | Current beat is the last of a fixed burst |

## Verification
The assertions take for granted that `load`, `stop` and `advance` are clean one-bit levels sampled only at rising edges and that `burst_code` and `interleave` matter only in a load cycle. The stimulus changes inputs on falling edges and holds the code and wrap bit steady around each load. It mixes mid-burst loads, a stop coinciding with a load, stalls in `advance`, advancing while idle, reserved codes and a full-page run that crosses column 255 more than once.

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen #(
  parameter int COL_W  = 8,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [COL_W-1:0]  start_col,
  input  logic [CODE_W-1:0] burst_code,
  input  logic              interleave,
  input  logic              advance,
  input  logic              stop,
  output logic [COL_W-1:0]  col,
  output logic              col_valid,
  output logic              last_beat
);

  localparam logic [CODE_W-1:0] CODE_FULL = {CODE_W{1'b1}};

  logic             act_q, full_q, ilv_q;
  logic [COL_W-1:0] start_q, beat_q, mask_q;
  logic [COL_W-1:0] mask_d;
  logic             full_d;

  always_comb begin
    full_d = 1'b0;
    case (burst_code)
      CODE_W'(0): mask_d = COL_W'(0);
      CODE_W'(1): mask_d = COL_W'(1);
      CODE_W'(2): mask_d = COL_W'(3);
      CODE_W'(3): mask_d = COL_W'(7);
      CODE_FULL: begin
        mask_d = {COL_W{1'b1}};
        full_d = 1'b1;
      end
      default:    mask_d = COL_W'(0);
    endcase
  end

  assign last_beat = act_q && !full_q && (beat_q == mask_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      full_q  <= 1'b0;
      ilv_q   <= 1'b0;
      start_q <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
    end else if (load) begin
      act_q   <= 1'b1;
      full_q  <= full_d;
      ilv_q   <= interleave;
      start_q <= start_col;
      beat_q  <= '0;
      mask_q  <= mask_d;
    end else if (stop) begin
      act_q <= 1'b0;
    end else if (act_q && advance) begin
      if (last_beat) act_q <= 1'b0;
      else           beat_q <= beat_q + COL_W'(1);
    end
  end

  logic [COL_W-1:0] offs;
  assign offs = (ilv_q && !full_q) ? (start_q ^ beat_q) : (start_q + beat_q);
  assign col       = (start_q & ~mask_q) | (offs & mask_q);
  assign col_valid = act_q;

  AST_LOAD_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> col_valid && col == $past(start_col)); // R2
  AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    stop && !load |=> !col_valid); // R8
  AST_LAST_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat && advance && !load && !stop |=> !col_valid); // R6
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    col_valid && !advance && !load && !stop |=> col_valid && $stable(col)); // R9
  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !col_valid && !load |=> !col_valid); // R9
  AST_FULL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    full_q && col_valid && advance && !load && !stop |=> col_valid && col == $past(col) + COL_W'(1)); // R7
  AST_LAST_ONLY_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |-> col_valid && !full_q); // R7

endmodule

// File: tb/sdram_burst_colgen_tb_top.sv
module sdram_burst_colgen_tb_top;
  logic       clk = 0, rst_n = 0;
  logic       load = 0, interleave = 0, advance = 0, stop = 0;
  logic [7:0] start_col = 0;
  logic [2:0] burst_code = 0;
  logic [7:0] col;
  logic       col_valid, last_beat;

  int checks = 0, errors = 0;
  string phase = "R1";

  int m_valid = 0, m_start = 0, m_beat = 0, m_len = 1, m_ilv = 0;

  always #2 clk = ~clk;

  sdram_burst_colgen dut_i (
    .clk(clk), .rst_n(rst_n), .load(load), .start_col(start_col),
    .burst_code(burst_code), .interleave(interleave), .advance(advance),
    .stop(stop), .col(col), .col_valid(col_valid), .last_beat(last_beat));

  function automatic int len_of(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 8;
      7: return 0;
      default: return 1; // R10 reserved codes
    endcase
  endfunction

  function automatic int exp_col();
    int base, rel;
    if (m_len == 0) return (m_start + m_beat) % 256;
    base = m_start - (m_start % m_len);
    rel  = m_start - base;
    if (m_ilv != 0) return base + (rel ^ m_beat);
    return base + ((rel + m_beat) % m_len);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid = 0; m_beat = 0;
    end else if (load) begin
      m_valid = 1; m_start = start_col; m_beat = 0;
      m_len = len_of(burst_code); m_ilv = interleave;
    end else if (stop) begin
      m_valid = 0;
    end else if (m_valid != 0 && advance) begin
      if (m_len != 0 && m_beat == m_len - 1) m_valid = 0;
      else m_beat = (m_beat + 1) % 256;
    end
  end

  task automatic chk(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    int e_last;
    e_last = (m_valid != 0 && m_len != 0 && m_beat == m_len - 1) ? 1 : 0;
    chk(phase, col_valid, m_valid, "col_valid");
    chk(phase, last_beat, e_last, "last_beat");
    if (m_valid != 0) chk(phase, col, exp_col(), "col");
  end

  task automatic go(int code, int ilv, int st);
    @(negedge clk);
    load = 1; burst_code = code[2:0]; interleave = ilv[0]; start_col = st[7:0];
    @(negedge clk);
    load = 0;
  endtask

  task automatic step(int n, int adv);
    for (int i = 0; i < n; i++) begin
      advance = adv[0];
      @(negedge clk);
    end
    advance = 0;
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", col_valid, 0, "reset col_valid");
    chk("R1", last_beat, 0, "reset last_beat");
    rst_n = 1;
    phase = "R9"; step(4, 1);           // advance while idle
    phase = "R4";
    go(2, 0, 6);     step(5, 1);        // 6,7,4,5
    go(3, 0, 8'h1D); step(9, 1);
    go(1, 0, 8'h33); step(3, 1);
    phase = "R5";
    go(3, 1, 8'h1D); step(9, 1);
    go(2, 1, 8'h42); step(5, 1);
    phase = "R3";
    go(0, 0, 8'h90); step(2, 1);
    phase = "R10";
    go(5, 0, 8'h91); step(2, 1);
    go(4, 1, 8'h17); step(2, 1);
    go(6, 0, 8'hA3); step(2, 1);
    phase = "R9";
    go(3, 0, 8'h44); step(3, 0); step(2, 1); step(4, 0); step(8, 1);
    phase = "R2";
    go(3, 0, 8'h50); step(3, 1);
    go(2, 1, 8'hC1); step(1, 1);
    go(7, 0, 8'h10); step(2, 1);
    phase = "R7";
    go(7, 1, 8'hFE); step(600, 1);
    phase = "R8";
    stop = 1; @(negedge clk); stop = 0; step(3, 1);
    go(3, 0, 8'h20); step(2, 1);
    stop = 1; @(negedge clk); stop = 0; step(2, 1);
    go(2, 0, 8'h30); step(1, 1);
    stop = 1; load = 1; start_col = 8'h77; burst_code = 3'd1; interleave = 0;
    @(negedge clk); stop = 0; load = 0; step(3, 1);
    phase = "R6";
    go(3, 1, 8'hF3); step(7, 1); step(2, 0); step(2, 1);
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule